// File: doc/BRIEF.md
# Linear Sample Ramp Interpolator

This block sits between a slow audio sample source and a fast sigma-delta modulator. A slow source that feeds a fast modulator directly produces a sample-and-hold staircase. Each step lands in a single fast clock and carries far more high-frequency energy than the original signal had. That energy can start self-sustaining tones in the modulator's feedback loop. This block replaces each step with a straight line. The line starts at the previous sample and arrives at the new one exactly one input period later.

Each sample is presented with a one-cycle strobe on the fast clock. The block holds the last sample as the current target. On a strobe it computes a signed fixed-point increment of (new − old) / N and restarts a fractional accumulator from the old target. The accumulator then advances by that increment on every fast clock. The period N is either a fixed parameter or the number of fast clocks between the last two strobes. On the N-th clock the accumulator is loaded with the target exactly, so rounding never carries over from one segment to the next. For stereo, place one instance per channel and drive both from the same strobe.

Top module: `ramp_interp`

## Requirements
- R1: After synchronous reset the output is 0. It stays 0 until the first strobe.
- R2: In the cycle after a strobe, the output equals the sample carried by the previous strobe, or 0 for the first strobe. The output therefore lags the input by one sample.
- R3: After a strobe with new sample b, previous sample a and period N, the output k clocks later (1 ≤ k < N) is floor((a·2^F + k·s) / 2^F). Here s = trunc((b − a)·2^F / N), rounded toward zero, and F is the FRAC parameter. For example, going from 10 to 5 with N = 20 and F = 16 gives 7 at k = 10.
- R4: Exactly N clocks after a strobe the output equals the new sample. It holds that value for as long as the next strobe is late.
- R5: The output always stays between the two endpoints of the current segment, inclusive.
- R6: A strobe that arrives before the ramp has finished restarts the ramp from the current target. In the next cycle the output equals the sample of the preceding strobe, whatever point the ramp had reached.
- R7: With MODE = PER_FIXED, every segment uses N = PERIOD.
- R8: With MODE = PER_MEASURED, the first strobe after reset uses N = PERIOD. Each later strobe uses N equal to the number of clock edges since the previous strobe, saturated at 2^CW − 1, where CW = clog2(PMAX + 1).
- R9: Samples and output are signed two's complement, DW bits wide. A full-scale ramp from −2^(DW−1) to 2^(DW−1) − 1 runs without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; the output updates on every edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe marking a new input sample |
| smp_in | input | DW | Signed input sample, valid while smp_stb is high |
| ramp_out | output | DW | Signed interpolated output to the modulator |

## Verification
Two states are hard to reach from the ports. The first is a strobe that cuts a ramp short: the restart value must come from the stored target and not from the partial accumulator. The second is the measured period reaching its saturation limit. The stimulus reaches the first by strobing four clocks into a twenty-clock ramp. It reaches the second by leaving a gap of one hundred clocks against a counter limit of 63, then checking that the measured-mode output lands on the target at clock 63 and not one clock earlier. A closed-form model, rather than an accumulator, predicts every output value on every clock for both a fixed-period and a measured-period instance.

// File: rtl/ramp_interp_pkg.sv
package ramp_interp_pkg;

    typedef enum logic {
        PER_FIXED    = 1'b0,
        PER_MEASURED = 1'b1
    } per_mode_e;

    localparam int DEF_FRAC = 16;

endpackage

// File: rtl/ramp_period_meter.sv
module ramp_period_meter
    import ramp_interp_pkg::*;
#(
    parameter per_mode_e   MODE   = PER_FIXED,
    parameter int unsigned PERIOD = 2268,
    parameter int unsigned CW     = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    output logic [CW-1:0] n_seg
);
    localparam logic [CW-1:0] CMAX    = '1;
    localparam logic [CW-1:0] N_FIXED = CW'(PERIOD);

    logic [CW-1:0] cnt_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CW'(1);
            seen_q <= 1'b0;
        end else if (strobe) begin
            cnt_q  <= CW'(1);
            seen_q <= 1'b1;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        if (MODE == PER_MEASURED && seen_q) n_seg = cnt_q;
        else                                n_seg = N_FIXED;
    end

    // R7 / R8: the period handed to the divider is never zero
    assert_period_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        strobe |-> n_seg != '0);

    // R8: the interval counter stops at its limit
    assert_count_saturates_R8: assert property (@(posedge clk) disable iff (rst)
        (!strobe && cnt_q == CMAX) |=> cnt_q == CMAX);

endmodule

// File: rtl/ramp_step_calc.sv
module ramp_step_calc #(
    parameter int unsigned DW   = 16,
    parameter int unsigned FRAC = 16,
    parameter int unsigned CW   = 12,
    parameter int unsigned SW   = DW + FRAC + 1
) (
    input  logic signed [DW-1:0] new_s,
    input  logic signed [DW-1:0] old_s,
    input  logic        [CW-1:0] n,
    output logic signed [SW-1:0] step
);
    logic signed [DW:0]   diff;
    logic signed [SW-1:0] num;
    logic signed [SW-1:0] den;

    always_comb begin
        diff = {new_s[DW-1], new_s} - {old_s[DW-1], old_s};
        num  = {diff, {FRAC{1'b0}}};
        den  = $signed({{(SW-CW){1'b0}}, n});
        step = num / den;
    end

endmodule

// File: rtl/ramp_accum.sv
module ramp_accum #(
    parameter int unsigned DW   = 16,
    parameter int unsigned FRAC = 16,
    parameter int unsigned CW   = 12,
    parameter int unsigned SW   = DW + FRAC + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  logic signed [DW-1:0] din,
    input  logic        [CW-1:0] n_seg,
    input  logic signed [SW-1:0] step,
    output logic signed [DW-1:0] y,
    output logic signed [DW-1:0] tgt
);
    localparam int unsigned AW = DW + FRAC;

    logic signed [AW-1:0] acc_q;
    logic signed [SW-1:0] step_q;
    logic signed [SW-1:0] sum_w;
    logic signed [DW-1:0] tgt_q;
    logic signed [DW-1:0] base_q;
    logic        [CW-1:0] k_q;
    logic        [CW-1:0] nper_q;
    logic        [CW-1:0] k_nxt;
    logic                 in_span;

    always_comb begin
        sum_w = {acc_q[AW-1], acc_q} + step_q;
        k_nxt = k_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            step_q <= '0;
            tgt_q  <= '0;
            base_q <= '0;
            k_q    <= CW'(1);
            nper_q <= CW'(1);
        end else if (strobe) begin
            acc_q  <= {tgt_q, {FRAC{1'b0}}};
            step_q <= step;
            base_q <= tgt_q;
            tgt_q  <= din;
            k_q    <= '0;
            nper_q <= n_seg;
        end else if (k_q != nper_q) begin
            k_q <= k_nxt;
            if (k_nxt == nper_q) acc_q <= {tgt_q, {FRAC{1'b0}}};
            else                 acc_q <= sum_w[AW-1:0];
        end
    end

    assign y   = acc_q[AW-1:FRAC];
    assign tgt = tgt_q;

    always_comb begin
        if (base_q <= tgt_q) in_span = (y >= base_q) && (y <= tgt_q);
        else                 in_span = (y <= base_q) && (y >= tgt_q);
    end

    // R2 / R6: a strobe restarts the output at the target held before it
    assert_restart_from_target_R2: assert property (@(posedge clk) disable iff (rst)
        strobe |=> y == $past(tgt_q));

    // R4: once the ramp is complete the output is frozen
    assert_hold_when_done_R4: assert property (@(posedge clk) disable iff (rst)
        (!strobe && k_q == nper_q) |=> $stable(y));

    // R5: the output never leaves the current segment
    assert_within_segment_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> in_span);

endmodule

// File: rtl/ramp_interp.sv
module ramp_interp
    import ramp_interp_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned FRAC   = DEF_FRAC,
    parameter int unsigned PMAX   = 4095,
    parameter int unsigned PERIOD = 2268,
    parameter per_mode_e   MODE   = PER_FIXED
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] smp_in,
    output logic signed [DW-1:0] ramp_out
);
    localparam int unsigned CW = $clog2(PMAX + 1);
    localparam int unsigned SW = DW + FRAC + 1;

    logic        [CW-1:0] n_seg;
    logic signed [SW-1:0] step;
    logic signed [DW-1:0] tgt;

    ramp_period_meter #(.MODE(MODE), .PERIOD(PERIOD), .CW(CW)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .strobe (smp_stb),
        .n_seg  (n_seg)
    );

    ramp_step_calc #(.DW(DW), .FRAC(FRAC), .CW(CW), .SW(SW)) u_step (
        .new_s (smp_in),
        .old_s (tgt),
        .n     (n_seg),
        .step  (step)
    );

    ramp_accum #(.DW(DW), .FRAC(FRAC), .CW(CW), .SW(SW)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .strobe (smp_stb),
        .din    (smp_in),
        .n_seg  (n_seg),
        .step   (step),
        .y      (ramp_out),
        .tgt    (tgt)
    );

endmodule

// File: tb/ramp_interp_test.sv
module ramp_interp_test;
    import ramp_interp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PER        = 20;
    localparam int PLIM       = 63;
    localparam longint SCALE  = 65536;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               stb = 1'b0;
    logic signed [15:0] din = '0;
    logic signed [15:0] y_f;
    logic signed [15:0] y_m;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ramp_interp #(.DW(16), .FRAC(16), .PMAX(PLIM), .PERIOD(PER), .MODE(PER_FIXED)) uut (
        .clk(clk), .rst(rst), .smp_stb(stb), .smp_in(din), .ramp_out(y_f));

    ramp_interp #(.DW(16), .FRAC(16), .PMAX(PLIM), .PERIOD(PER), .MODE(PER_MEASURED)) uut_m (
        .clk(clk), .rst(rst), .smp_stb(stb), .smp_in(din), .ramp_out(y_m));

    // Closed-form reference, index 0 = fixed period, 1 = measured period
    longint m_tgt[2], m_base[2], m_step[2];
    int     m_k[2], m_n[2];
    int     gap  = 1;
    bit     seen = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_tgt[i] = 0; m_base[i] = 0; m_step[i] = 0; m_k[i] = 1; m_n[i] = 1;
            end
            gap = 1; seen = 1'b0;
        end else if (stb) begin
            int nm;
            nm = seen ? ((gap > PLIM) ? PLIM : gap) : PER;
            for (int i = 0; i < 2; i++) begin
                m_n[i]    = (i == 0) ? PER : nm;
                m_step[i] = ((longint'(din) - m_tgt[i]) * SCALE) / longint'(m_n[i]);
                m_base[i] = m_tgt[i];
                m_tgt[i]  = longint'(din);
                m_k[i]    = 0;
            end
            gap = 1; seen = 1'b1;
        end else begin
            if (gap < 100000) gap++;
            for (int i = 0; i < 2; i++) if (m_k[i] < m_n[i]) m_k[i]++;
        end
    end

    function automatic longint expect_y(int i);
        if (m_k[i] >= m_n[i]) return m_tgt[i];
        return (m_base[i] * SCALE + longint'(m_k[i]) * m_step[i]) >>> 16;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_true(string req, bit cond, longint act, longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R3 (also R4, R5, R7, R8): every clock against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 fixed model", longint'(y_f), expect_y(0));
            check("R3 measured model", longint'(y_m), expect_y(1));
        end
    end

    task automatic strobe_in(input logic signed [15:0] x);
        stb = 1'b1; din = x;
        @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 output in reset", longint'(y_f), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 fixed idle after reset", longint'(y_f), 0);
        check("R1 measured idle after reset", longint'(y_m), 0);

        // first segment 0 -> 10, default period for both
        strobe_in(16'sd10);
        check("R2 first strobe lag", longint'(y_f), 0);
        repeat (19) @(negedge clk);
        check("R7 fixed k=19 of 20", longint'(y_f), 9);
        check("R8 first segment uses PERIOD", longint'(y_m), 9);

        // 10 -> 5, distance 20
        strobe_in(16'sd5);
        check("R2 lag previous sample", longint'(y_f), 10);
        repeat (10) @(negedge clk);
        check("R3 midpoint 10->5", longint'(y_f), 7);
        check("R3 midpoint measured", longint'(y_m), 7);
        repeat (10) @(negedge clk);
        check("R4 lands on target", longint'(y_f), 5);

        // full scale
        repeat (8) @(negedge clk);
        strobe_in(-16'sd32768);
        repeat (29) @(negedge clk);
        strobe_in(16'sd32767);
        check("R9 start at negative full scale", longint'(y_f), -32768);
        repeat (10) @(negedge clk);
        check_true("R9 no wrap mid ramp", (y_f > -16'sd32768) && (y_f < 16'sd32767),
                   longint'(y_f), -1);
        repeat (10) @(negedge clk);
        check("R9 reaches positive full scale", longint'(y_f), 32767);
        repeat (10) @(negedge clk);
        check("R4 late strobe holds target", longint'(y_f), 32767);

        // early strobe
        strobe_in(16'sd1000);
        repeat (4) @(negedge clk);
        strobe_in(-16'sd1000);
        check("R6 early restart fixed", longint'(y_f), 1000);
        check("R6 early restart measured", longint'(y_m), 1000);
        repeat (3) @(negedge clk);
        check_true("R5 inside segment", (y_f < 16'sd1000) && (y_f > -16'sd1000),
                   longint'(y_f), 0);

        // measured period 40
        repeat (36) @(negedge clk);
        strobe_in(16'sd0);
        repeat (39) @(negedge clk);
        strobe_in(16'sd6300);
        repeat (39) @(negedge clk);
        check("R7 fixed done after 20", longint'(y_f), 6300);
        check_true("R8 measured not done at 39", y_m != 16'sd6300, longint'(y_m), 6300 - 1);
        repeat (1) @(negedge clk);
        check("R8 measured done at 40", longint'(y_m), 6300);

        // saturation: gap of 100 against limit 63
        repeat (59) @(negedge clk);
        strobe_in(-16'sd6300);
        repeat (62) @(negedge clk);
        check_true("R8 saturated not done at 62", y_m != -16'sd6300, longint'(y_m), -6300 + 1);
        repeat (1) @(negedge clk);
        check("R8 saturated done at 63", longint'(y_m), -6300);
        repeat (5) @(negedge clk);
        check("R4 measured hold", longint'(y_m), -6300);

        finish_run();
    end

endmodule